// File: doc/BRIEF.md
# Three-phase carrier PWM generator

The block drives the three phase pairs of a motor inverter (U, V and W, each with a positive and a negative output) from one shared carrier counter. The counter advances on a count-source enable pulse. It runs either as a triangle, counting up to a reload value and back down, or as a sawtooth that counts up and wraps. Each phase compares its width value with the carrier to decide when its positive output is active. The negative output is the logical complement. The outputs are raw, so dead time is added further down the path.

Width values, the reload value, the carrier shape and the per-phase hold commands are sampled only at the carrier boundary. That boundary is the triangle valley or the sawtooth wrap, and the first enable pulse after reset also counts as one. Software may therefore write new values at any time without glitching the cycle in progress. A carrier interrupt is raised once every K boundaries. A low level on the cutoff input latches an inactive state on all six outputs. That state stays until software removes the output enable and sets it again.

Top module: `tri_phase_pwm`

## Requirements
- R1: In sawtooth mode (`tri_mode`=0) the counter steps 0,1,…,m on successive ticks and wraps to 0, so a carrier cycle lasts m+1 ticks, where m is `carrier_top`.
- R2: In triangular mode (`tri_mode`=1) the counter steps up 0…m and then down m…0, one value per tick, so a carrier cycle lasts 2·(m+1) ticks.
- R3: In sawtooth mode a phase is active while the counter is below its width n, giving min(n, m+1) active ticks per cycle. The cycle starts at counter 0.
- R4: In triangular mode a phase is active on each slope while counter + n > m. This gives an active pulse of 2·min(n, m+1) ticks centred on the peak.
- R5: With `dual_en`=1 the up slope uses the phase's `width_a` field and the down slope uses its `width_b` field. With `dual_en`=0, `width_a` serves both slopes and `width_b` is ignored.
- R6: Widths, m, the carrier mode, `dual_en` and the hold commands are sampled only at a carrier boundary. A change made mid-cycle first shows in the next cycle.
- R7: `pos_act_hi`=1 makes the active level of the positive outputs high, and 0 makes it low. `neg_act_hi` does the same, independently, for the negative outputs.
- R8: A phase with its `force_en` bit set holds its positive output active for the whole cycle when its `force_lvl` bit is 1, and inactive when that bit is 0. Bit 0 is U, bit 1 is V and bit 2 is W, and the same mapping applies to the output vectors.
- R9: `carrier_irq` pulses for one clock, in the clock after the boundary tick, on every K-th boundary, where K is `irq_div` (1 to 15, and 0 behaves as 1).
- R10: While `motor_mode` and `out_en` are both 1, a low `cutoff_n` drives all six outputs to their inactive levels from the next clock on. This state is sticky until `out_en` is taken low. A low `cutoff_n` while `motor_mode` is 0 has no effect.
- R11: All six outputs sit at their inactive levels while `motor_mode` or `out_en` is 0, and before the first tick after reset.
- R12: The positive and negative outputs of a phase are never active at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count-source enable, one clock per carrier step |
| carrier_top | input | CW | Carrier reload value m |
| tri_mode | input | 1 | 1 triangular, 0 sawtooth |
| dual_en | input | 1 | Separate down-slope widths |
| width_a | input | 3·CW | Up-slope (or only) width per phase, U in the low field |
| width_b | input | 3·CW | Down-slope width per phase |
| force_en | input | 3 | Per-phase constant-level hold |
| force_lvl | input | 3 | Held level, 1 = active |
| pos_act_hi | input | 1 | Positive outputs active high |
| neg_act_hi | input | 1 | Negative outputs active high |
| irq_div | input | 4 | Interrupt decimation K |
| motor_mode | input | 1 | Three-phase function enable |
| out_en | input | 1 | Output enable, low clears cutoff |
| cutoff_n | input | 1 | Forced cutoff, active low |
| phase_pos | output | 3 | Positive outputs U, V, W |
| phase_neg | output | 3 | Negative outputs U, V, W |
| carrier_irq | output | 1 | Carrier interrupt pulse |

## Verification
The bench builds the block with CW=8. This keeps every carrier cycle a few dozen clocks long, so it can sweep the reload values 0 to 4 against widths 0 to 7 in both carrier shapes, and every up/down width pair in dual mode. Those sweeps reach the saturation case where the width exceeds m+1, the zero width, and the single-tick carrier at m=0. Sparse ticks, the decimation extremes K=0 and K=15, and mid-cycle writes are also short enough to measure clock by clock.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

    parameter int DIV_W = 4;

    typedef enum logic {
        SLOPE_UP   = 1'b0,
        SLOPE_DOWN = 1'b1
    } slope_e;

    typedef enum logic {
        CARRIER_SAW = 1'b0,
        CARRIER_TRI = 1'b1
    } carrier_e;

endpackage

// File: rtl/pwm3_carrier.sv
module pwm3_carrier
    import pwm3_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [CW-1:0]       top_in,
    input  logic                tri_in,
    input  logic [DIV_W-1:0]    irq_div,
    output logic [CW-1:0]       cnt,
    output logic [CW-1:0]       top,
    output slope_e              slope,
    output carrier_e            mode,
    output logic                started,
    output logic                load,
    output logic                irq
);

    typedef struct packed {
        logic [CW-1:0]    cnt;
        logic [CW-1:0]    top;
        slope_e           slope;
        carrier_e         mode;
        logic             started;
        logic [DIV_W-1:0] div;
        logic             irq;
    } car_s;

    car_s s_d, s_q;
    logic wrap;
    logic [DIV_W-1:0] k_eff;
    logic [DIV_W:0]   div_next;

    always_comb begin
        s_d      = s_q;
        wrap     = 1'b0;
        load     = 1'b0;
        s_d.irq  = 1'b0;
        k_eff    = (irq_div == '0) ? DIV_W'(1) : irq_div;
        div_next = {1'b0, s_q.div} + (DIV_W+1)'(1);
        if (tick) begin
            if (!s_q.started) begin
                load        = 1'b1;
                s_d.started = 1'b1;
                s_d.cnt     = '0;
                s_d.slope   = SLOPE_UP;
                s_d.mode    = carrier_e'(tri_in);
                s_d.top     = top_in;
            end else if (s_q.mode == CARRIER_TRI) begin
                if (s_q.slope == SLOPE_UP) begin
                    if (s_q.cnt == s_q.top) s_d.slope = SLOPE_DOWN;
                    else                    s_d.cnt   = s_q.cnt + CW'(1);
                end else begin
                    if (s_q.cnt == '0) wrap      = 1'b1;
                    else               s_d.cnt   = s_q.cnt - CW'(1);
                end
            end else begin
                if (s_q.cnt == s_q.top) wrap    = 1'b1;
                else                    s_d.cnt = s_q.cnt + CW'(1);
            end
            if (wrap) begin
                load      = 1'b1;
                s_d.cnt   = '0;
                s_d.slope = SLOPE_UP;
                s_d.mode  = carrier_e'(tri_in);
                s_d.top   = top_in;
                if (div_next >= {1'b0, k_eff}) begin
                    s_d.irq = 1'b1;
                    s_d.div = '0;
                end else begin
                    s_d.div = div_next[DIV_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt     = s_q.cnt;
    assign top     = s_q.top;
    assign slope   = s_q.slope;
    assign mode    = s_q.mode;
    assign started = s_q.started;
    assign irq     = s_q.irq;

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= s_q.top);

    // R2
    slope_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.slope == SLOPE_DOWN) |-> (s_q.mode == CARRIER_TRI));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(s_q.cnt) && $stable(s_q.top) && $stable(s_q.mode)));

    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.irq |-> $past(tick));

endmodule

// File: rtl/pwm3_phase.sv
module pwm3_phase
    import pwm3_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] width_up,
    input  logic [CW-1:0] width_dn,
    input  logic          dual_en,
    input  logic          force_en,
    input  logic          force_lvl,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] top,
    input  slope_e        slope,
    input  carrier_e      mode,
    output logic          active
);

    typedef struct packed {
        logic [CW-1:0] wu;
        logic [CW-1:0] wd;
        logic          fen;
        logic          flv;
    } ph_s;

    ph_s s_d, s_q;
    logic [CW-1:0] w_sel;
    logic [CW:0]   sum;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.wu  = width_up;
            s_d.wd  = dual_en ? width_dn : width_up;
            s_d.fen = force_en;
            s_d.flv = force_lvl;
        end
        w_sel = (slope == SLOPE_DOWN) ? s_q.wd : s_q.wu;
        sum   = {1'b0, cnt} + {1'b0, w_sel};
        if (s_q.fen)                  active = s_q.flv;
        else if (mode == CARRIER_TRI) active = (sum > {1'b0, top});
        else                          active = (cnt < w_sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R6
    width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(s_q));

endmodule

// File: rtl/pwm3_guard.sv
module pwm3_guard (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] active,
    input  logic       started,
    input  logic       motor_mode,
    input  logic       out_en,
    input  logic       cutoff_n,
    input  logic       pos_hi,
    input  logic       neg_hi,
    output logic [2:0] pos_out,
    output logic [2:0] neg_out
);

    typedef struct packed {
        logic cut;
    } grd_s;

    grd_s s_d, s_q;
    logic drive;
    logic [2:0] pos_act, neg_act;

    always_comb begin
        s_d = s_q;
        if (!out_en)                      s_d.cut = 1'b0;
        else if (motor_mode && !cutoff_n) s_d.cut = 1'b1;
        drive   = motor_mode && out_en && started && !s_q.cut;
        pos_act = drive ? active  : 3'b000;
        neg_act = drive ? ~active : 3'b000;
        pos_out = pos_hi ? pos_act : ~pos_act;
        neg_out = neg_hi ? neg_act : ~neg_act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R12
    no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pos_out ~^ {3{pos_hi}}) & (neg_out ~^ {3{neg_hi}})) == 3'b000);

    // R10
    sticky_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cut && out_en) |=> s_q.cut);

    // R10
    cut_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cut |-> (pos_out == {3{!pos_hi}} && neg_out == {3{!neg_hi}}));

    // R11
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(motor_mode && out_en) |-> (pos_out == {3{!pos_hi}} && neg_out == {3{!neg_hi}}));

endmodule

// File: rtl/tri_phase_pwm.sv
module tri_phase_pwm
    import pwm3_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CW-1:0]     carrier_top,
    input  logic              tri_mode,
    input  logic              dual_en,
    input  logic [3*CW-1:0]   width_a,
    input  logic [3*CW-1:0]   width_b,
    input  logic [2:0]        force_en,
    input  logic [2:0]        force_lvl,
    input  logic              pos_act_hi,
    input  logic              neg_act_hi,
    input  logic [DIV_W-1:0]  irq_div,
    input  logic              motor_mode,
    input  logic              out_en,
    input  logic              cutoff_n,
    output logic [2:0]        phase_pos,
    output logic [2:0]        phase_neg,
    output logic              carrier_irq
);

    localparam int NPH = 3;

    logic [CW-1:0] cnt, top;
    slope_e        slope;
    carrier_e      mode;
    logic          started, load;
    logic [NPH-1:0] active;

    pwm3_carrier #(.CW(CW)) u_carrier (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .top_in  (carrier_top),
        .tri_in  (tri_mode),
        .irq_div (irq_div),
        .cnt     (cnt),
        .top     (top),
        .slope   (slope),
        .mode    (mode),
        .started (started),
        .load    (load),
        .irq     (carrier_irq)
    );

    for (genvar i = 0; i < NPH; i++) begin : g_phase
        pwm3_phase #(.CW(CW)) u_phase (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load),
            .width_up  (width_a[i*CW +: CW]),
            .width_dn  (width_b[i*CW +: CW]),
            .dual_en   (dual_en),
            .force_en  (force_en[i]),
            .force_lvl (force_lvl[i]),
            .cnt       (cnt),
            .top       (top),
            .slope     (slope),
            .mode      (mode),
            .active    (active[i])
        );
    end

    pwm3_guard u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .started    (started),
        .motor_mode (motor_mode),
        .out_en     (out_en),
        .cutoff_n   (cutoff_n),
        .pos_hi     (pos_act_hi),
        .neg_hi     (neg_act_hi),
        .pos_out    (phase_pos),
        .neg_out    (phase_neg)
    );

endmodule

// File: tb/tri_phase_pwm_test.sv
module tri_phase_pwm_test;

    localparam int CW = 8;

    logic clk = 0;
    logic rst_n = 0;
    logic tick = 0;
    logic [CW-1:0] top_v = 0;
    logic tri_m = 0, dual = 0;
    logic [3*CW-1:0] wa = 0, wb = 0;
    logic [2:0] fen = 0, flv = 0;
    logic pos_hi = 1, neg_hi = 1;
    logic [3:0] kdiv = 1;
    logic motor = 1, oen = 1, cut_n = 1;
    logic [2:0] ph_p, ph_n;
    logic irq;

    int nchk = 0, nfail = 0, overlap = 0;
    bit tick_on = 0;
    int gap = 1, gcnt = 0;

    tri_phase_pwm #(.CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .carrier_top(top_v),
        .tri_mode(tri_m), .dual_en(dual), .width_a(wa), .width_b(wb),
        .force_en(fen), .force_lvl(flv), .pos_act_hi(pos_hi), .neg_act_hi(neg_hi),
        .irq_div(kdiv), .motor_mode(motor), .out_en(oen), .cutoff_n(cut_n),
        .phase_pos(ph_p), .phase_neg(ph_n), .carrier_irq(irq)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        if (tick_on) begin
            tick <= (gcnt == 0);
            gcnt = (gcnt + 1 >= gap) ? 0 : gcnt + 1;
        end else begin
            tick <= 1'b0;
            gcnt = 0;
        end
    end

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat(int n, int m);
        return (n < m + 1) ? n : m + 1;
    endfunction

    // clocks between two carrier interrupts, active clocks per phase
    task automatic measure(output int per, output int a0, output int a1,
                           output int a2, output int n0);
        int guard = 0;
        do begin @(negedge clk); guard++; end while (!irq && guard < 5000);
        per = 0; a0 = 0; a1 = 0; a2 = 0; n0 = 0; guard = 0;
        do begin
            per++;
            if (ph_p[0] == pos_hi) a0++;
            if (ph_p[1] == pos_hi) a1++;
            if (ph_p[2] == pos_hi) a2++;
            if (ph_n[0] == neg_hi) n0++;
            for (int k = 0; k < 3; k++)
                if (ph_p[k] == pos_hi && ph_n[k] == neg_hi) overlap++;
            @(negedge clk); guard++;
        end while (!irq && guard < 5000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        int per, a0, a1, a2, n0, cnt;
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (4) @(negedge clk);
        // R11: no tick yet, outputs inactive, no interrupt
        chk("R11 pos before first tick", ph_p, 0);
        chk("R11 neg before first tick", ph_n, 0);
        chk("R9 irq before first tick", irq, 0);
        tick_on = 1;

        // R1 R2 R3 R4 sweep, width_b ignored with dual off (R5)
        for (int t = 0; t < 2; t++)
            for (int m = 0; m < 5; m++)
                for (int n = 0; n < 6; n++) begin
                    tri_m = t[0]; top_v = CW'(m); dual = 0;
                    wa = {CW'(n + 2), CW'(n + 1), CW'(n)};
                    wb = {3{CW'(7)}};
                    measure(per, a0, a1, a2, n0);
                    measure(per, a0, a1, a2, n0);
                    if (t == 0) begin
                        chk("R1 saw period", per, m + 1);
                        chk("R3 saw U width", a0, sat(n, m));
                        chk("R3 saw V width", a1, sat(n + 1, m));
                        chk("R3 saw W width", a2, sat(n + 2, m));
                    end else begin
                        chk("R2 tri period", per, 2 * (m + 1));
                        chk("R4 tri U width", a0, 2 * sat(n, m));
                        chk("R4 tri V width", a1, 2 * sat(n + 1, m));
                        chk("R4 tri W width", a2, 2 * sat(n + 2, m));
                    end
                end

        // R5 dual widths
        for (int na = 0; na < 5; na++)
            for (int nb = 0; nb < 5; nb++) begin
                tri_m = 1; top_v = 3; dual = 1;
                wa = {3{CW'(na)}}; wb = {3{CW'(nb)}};
                measure(per, a0, a1, a2, n0);
                measure(per, a0, a1, a2, n0);
                chk("R5 dual U width", a0, sat(na, 3) + sat(nb, 3));
                chk("R5 dual W width", a2, sat(na, 3) + sat(nb, 3));
            end
        dual = 0;

        // R6 mid-cycle write takes effect next cycle
        tri_m = 0; top_v = 7; wa = {3{CW'(2)}};
        measure(per, a0, a1, a2, n0);
        measure(per, a0, a1, a2, n0);
        per = 0; a0 = 0;
        do begin
            per++;
            if (ph_p[0] == pos_hi) a0++;
            if (per == 3) begin wa = {3{CW'(6)}}; top_v = 3; end
            @(negedge clk);
        end while (!irq);
        chk("R6 old period kept", per, 8);
        chk("R6 old width kept", a0, 2);
        measure(per, a0, a1, a2, n0);
        chk("R6 new period", per, 4);
        chk("R6 new width", a0, 4);

        // R1 R4 with sparse ticks
        gap = 3; tri_m = 0; top_v = 2; wa = {3{CW'(1)}};
        measure(per, a0, a1, a2, n0);
        measure(per, a0, a1, a2, n0);
        chk("R1 sparse saw period", per, 9);
        chk("R3 sparse saw width", a0, 3);
        gap = 2; tri_m = 1; top_v = 1;
        measure(per, a0, a1, a2, n0);
        measure(per, a0, a1, a2, n0);
        chk("R2 sparse tri period", per, 8);
        chk("R4 sparse tri width", a0, 4);
        gap = 1;

        // R7 polarity
        tri_m = 0; top_v = 4; wa = {3{CW'(2)}};
        for (int pp = 0; pp < 2; pp++)
            for (int nn = 0; nn < 2; nn++) begin
                pos_hi = pp[0]; neg_hi = nn[0];
                measure(per, a0, a1, a2, n0);
                measure(per, a0, a1, a2, n0);
                chk("R7 pos active count", a0, 2);
                chk("R7 neg active count", n0, 3);
            end
        pos_hi = 0; neg_hi = 1; oen = 0;
        @(negedge clk); @(negedge clk);
        chk("R11 idle pos level low-active", ph_p, 7);
        chk("R11 idle neg level high-active", ph_n, 0);
        oen = 1; pos_hi = 1; neg_hi = 1;

        // R8 forced levels
        fen = 3'b011; flv = 3'b001;
        measure(per, a0, a1, a2, n0);
        measure(per, a0, a1, a2, n0);
        chk("R8 U held active", a0, 5);
        chk("R8 V held inactive", a1, 0);
        chk("R8 W normal", a2, 2);
        fen = 0; flv = 0;

        // R9 decimation
        top_v = 2;
        measure(per, a0, a1, a2, n0);
        kdiv = 3;
        measure(per, a0, a1, a2, n0);
        measure(per, a0, a1, a2, n0);
        chk("R9 K=3 spacing", per, 9);
        kdiv = 0;
        measure(per, a0, a1, a2, n0);
        measure(per, a0, a1, a2, n0);
        chk("R9 K=0 spacing", per, 3);
        kdiv = 15;
        measure(per, a0, a1, a2, n0);
        measure(per, a0, a1, a2, n0);
        chk("R9 K=15 spacing", per, 45);
        kdiv = 1;
        measure(per, a0, a1, a2, n0);

        // R10 cutoff
        top_v = 4; wa = {3{CW'(2)}};
        measure(per, a0, a1, a2, n0);
        cut_n = 0;
        @(negedge clk);
        chk("R10 cutoff pos", ph_p, 0);
        chk("R10 cutoff neg", ph_n, 0);
        cut_n = 1;
        cnt = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (ph_p != 0 || ph_n != 0) cnt++;
        end
        chk("R10 cutoff sticky", cnt, 0);
        oen = 0; @(negedge clk); oen = 1;
        measure(per, a0, a1, a2, n0);
        measure(per, a0, a1, a2, n0);
        chk("R10 resume after re-enable", a0, 2);
        motor = 0;
        @(negedge clk); @(negedge clk);
        chk("R11 mode off pos", ph_p, 0);
        chk("R11 mode off neg", ph_n, 0);
        cut_n = 0; @(negedge clk); @(negedge clk);
        cut_n = 1; @(negedge clk);
        motor = 1;
        measure(per, a0, a1, a2, n0);
        measure(per, a0, a1, a2, n0);
        chk("R10 cutoff ignored with mode off", a0, 2);

        chk("R12 no pos/neg overlap", overlap, 0);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule